// File: doc/BRIEF.md
# Debug Register Access Permission Arbiter

This block sits between a debug access port and a bank of debug registers and decides, in the same cycle an access is presented, how that access is answered. Each access carries a register index, a read or write flag and a flag telling whether it came from the memory-mapped port or from the external debug port. The arbiter looks at the power, lock and authentication state, finds the highest-priority condition that applies to the addressed register, and turns that register's permission code into an error, a normal read/write, a read-only access, or a write that is quietly dropped.

Every register has a row in a parameter table holding one 3-bit code for each of six ordered conditions. A code of "continue" lets the scan pass a true condition and go on to the next one. When an access fails only because external debug access is not authorised, a sticky denial flag is set. Software clears this flag by reading the status register, and the flag appears in that register's read data. A separate active-low debug-domain reset also clears it.

Top module: `dbg_perm_arbiter`

## Requirements
- R1: When `dbg_pwr_on` is 0, every valid access gets an error (code 0), no write is enabled, and the sticky flag keeps its value.
- R2: With debug power on, conditions are scanned in this priority order: processor powered down (`pwr_up`=0), double lock (`dbl_lock`=1), OS lock (`os_lock`=1), external debug not allowed (`ext_dbg_allow`=0), software lock, and default (always true). The first true condition whose code is not 7 selects the response.
- R3: The software-lock condition is true only when `sw_lock`=1 and `acc_mmio`=1. For the external debug port (`acc_mmio`=0) it is never true.
- R4: A table row holds the code for condition c (0..5 in R2 order) at bits [3c+2:3c]. Codes are 0 error, 1 RW, 2 RO, 3 RO/WI, 4 WI and 7 continue. Codes 5 and 6 are answered as error. `rsp_code` carries the resolved code.
- R5: `rsp_wr_en` is 1 only for a valid write whose code is RW. A write resolved to RO, RO/WI or WI is dropped and is not reported as an error.
- R6: A valid read resolved to RW, RO or RO/WI returns `reg_rdata`. A read resolved to WI or error, any write, and an idle cycle all return zero.
- R7: A register index of `NUM_REGS` or more gets an error.
- R8: A valid access that ends in an error won by the external-debug-not-allowed condition sets `sticky_denied` from the next cycle on.
- R9: `sticky_denied` does not change on errors won by any other condition, on accesses with debug power off, or on idle cycles.
- R10: A successful read of register `STATUS_IDX` returns the current `sticky_denied` value at bit `SDAD_BIT`, in place of that bit of `reg_rdata`, and clears the flag from the next cycle on.
- R11: `dbg_rst_n` low clears `sticky_denied`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug-domain clock |
| dbg_rst_n | input | 1 | Active-low debug-domain reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mmio | input | 1 | 1 = memory-mapped port, 0 = external debug port |
| acc_idx | input | IDX_W | Register index |
| dbg_pwr_on | input | 1 | Debug power domain is up |
| pwr_up | input | 1 | Processor power domain registers reachable |
| dbl_lock | input | 1 | Double lock engaged |
| os_lock | input | 1 | OS lock engaged |
| ext_dbg_allow | input | 1 | Authentication permits external debug access |
| sw_lock | input | 1 | Software lock engaged |
| reg_rdata | input | DATA_W | Read data from the register file |
| rsp_code | output | 3 | Resolved permission code |
| rsp_err | output | 1 | Access answered with an error |
| rsp_wr_en | output | 1 | Write enable toward the register file |
| rsp_rdata | output | DATA_W | Read data returned to the port |
| sticky_denied | output | 1 | Sticky authentication-denial flag |

## Verification
Two events can land on the flag in the same cycle. In the first, a status read returns the flag's current value while also clearing it for the next cycle. In the second, an authentication error sets the flag just after an earlier status read, so the set and the clear act in back-to-back cycles. The bench causes both on purpose: it sets the flag, reads the status register twice in a row (expecting 1 and then 0), and then alternates denied accesses with status reads. A per-cycle model predicts the returned bit and the next flag value, and random traffic over all condition mixes gets the same per-cycle comparison.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   localparam int NCOND = 6;
   localparam int CODE_W = 3;
   localparam int ROW_W = NCOND * CODE_W;

   localparam int C_OFF  = 0;
   localparam int C_DLK  = 1;
   localparam int C_OSLK = 2;
   localparam int C_AUTH = 3;
   localparam int C_SLK  = 4;
   localparam int C_DFLT = 5;

   typedef enum logic [CODE_W-1:0] {
      PC_ERR  = 3'd0,
      PC_RW   = 3'd1,
      PC_RO   = 3'd2,
      PC_ROWI = 3'd3,
      PC_WI   = 3'd4,
      PC_CONT = 3'd7
   } perm_code_e;

   // packs one register's codes, lowest condition in the low bits
   function automatic logic [ROW_W-1:0] mk_row(
      input logic [2:0] off, input logic [2:0] dlk, input logic [2:0] oslk,
      input logic [2:0] auth, input logic [2:0] slk, input logic [2:0] dflt);
      return {dflt, slk, auth, oslk, dlk, off};
   endfunction

   // index 0: status register, 1: read-only register, 2: plain register,
   // 3: register that drops writes under OS lock
   localparam logic [4*ROW_W-1:0] DEFAULT_TABLE = {
      mk_row(3'd0, 3'd0, 3'd4, 3'd0, 3'd3, 3'd1),
      mk_row(3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd1),
      mk_row(3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd2),
      mk_row(3'd7, 3'd7, 3'd7, 3'd7, 3'd3, 3'd1)
   };

endpackage

// File: rtl/dpa_row_select.sv
module dpa_row_select
   import dpa_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int IDX_W = 3,
   parameter logic [NUM_REGS*ROW_W-1:0] PERM_TABLE = '0
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [ROW_W-1:0] row_o,
   output logic             idx_ok_o
);

   logic [ROW_W-1:0] rows [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
      assign rows[r] = PERM_TABLE[r*ROW_W +: ROW_W];
   end

   always_comb begin
      row_o = '0;
      idx_ok_o = 1'b0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (32'(idx_i) == r) begin
            row_o = rows[r];
            idx_ok_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dpa_cond_scan.sv
module dpa_cond_scan
   import dpa_pkg::*;
(
   input  logic [NCOND-1:0]  hit_i,
   input  logic [ROW_W-1:0]  row_i,
   output logic [CODE_W-1:0] code_o,
   output logic [2:0]        win_o
);

   logic [CODE_W-1:0] cond_code [NCOND];
   logic [NCOND-1:0]  take;

   for (genvar c = 0; c < NCOND; c++) begin : g_cond
      assign cond_code[c] = row_i[c*CODE_W +: CODE_W];
      assign take[c] = hit_i[c] && (cond_code[c] != PC_CONT);
   end

   // the lowest index that takes wins; walking downward lets it overwrite
   always_comb begin
      code_o = PC_ERR;
      win_o = 3'(NCOND);
      for (int c = NCOND - 1; c >= 0; c--) begin
         if (take[c]) begin
            code_o = cond_code[c];
            win_o = 3'(c);
         end
      end
   end

endmodule

// File: rtl/dpa_sticky.sv
module dpa_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else if (set_i) begin
         q_o <= 1'b1;
      end else if (clr_i) begin
         q_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dbg_perm_arbiter.sv
module dbg_perm_arbiter
   import dpa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM_REGS = 4,
   parameter int IDX_W = 3,
   parameter int STATUS_IDX = 0,
   parameter int SDAD_BIT = 6,
   parameter logic [NUM_REGS*ROW_W-1:0] PERM_TABLE = DEFAULT_TABLE
) (
   input  logic              clk,
   input  logic              dbg_rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_mmio,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic              dbg_pwr_on,
   input  logic              pwr_up,
   input  logic              dbl_lock,
   input  logic              os_lock,
   input  logic              ext_dbg_allow,
   input  logic              sw_lock,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [2:0]        rsp_code,
   output logic              rsp_err,
   output logic              rsp_wr_en,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              sticky_denied
);

   localparam int IDX_SPAN = 1 << IDX_W;

   if (NUM_REGS < 1 || NUM_REGS > IDX_SPAN) begin : g_bad_regs
      $error("NUM_REGS must lie in 1..2**IDX_W");
   end
   if (STATUS_IDX < 0 || STATUS_IDX >= NUM_REGS) begin : g_bad_status
      $error("STATUS_IDX outside the table");
   end
   if (SDAD_BIT < 0 || SDAD_BIT >= DATA_W) begin : g_bad_bit
      $error("SDAD_BIT outside the data word");
   end
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk_row
      if (PERM_TABLE[r*ROW_W + C_DFLT*CODE_W +: CODE_W] == 3'd7) begin : g_bad_dflt
         $error("default column may not hold the continue code");
      end
   end

   logic [ROW_W-1:0]  row;
   logic              idx_ok;
   logic [NCOND-1:0]  hit;
   logic [CODE_W-1:0] scan_code;
   logic [2:0]        win;
   logic [CODE_W-1:0] eff_code;
   logic              set_flag;
   logic              clr_flag;
   logic              data_read;
   logic              is_status;

   dpa_row_select #(
      .NUM_REGS  (NUM_REGS),
      .IDX_W     (IDX_W),
      .PERM_TABLE(PERM_TABLE)
   ) u_row (
      .idx_i   (acc_idx),
      .row_o   (row),
      .idx_ok_o(idx_ok)
   );

   assign hit[C_OFF]  = !pwr_up;
   assign hit[C_DLK]  = dbl_lock;
   assign hit[C_OSLK] = os_lock;
   assign hit[C_AUTH] = !ext_dbg_allow;
   assign hit[C_SLK]  = sw_lock && acc_mmio;
   assign hit[C_DFLT] = 1'b1;

   dpa_cond_scan u_scan (
      .hit_i (hit),
      .row_i (row),
      .code_o(scan_code),
      .win_o (win)
   );

   always_comb begin
      eff_code = PC_ERR;
      if (dbg_pwr_on && idx_ok) begin
         case (scan_code)
            PC_RW, PC_RO, PC_ROWI, PC_WI: eff_code = scan_code;
            default:                      eff_code = PC_ERR;
         endcase
      end
   end

   assign rsp_code  = eff_code;
   assign rsp_err   = acc_valid && (eff_code == PC_ERR);
   assign rsp_wr_en = acc_valid && acc_write && (eff_code == PC_RW);
   assign data_read = acc_valid && !acc_write &&
                      (eff_code == PC_RW || eff_code == PC_RO || eff_code == PC_ROWI);
   assign is_status = (32'(acc_idx) == STATUS_IDX);

   always_comb begin
      rsp_rdata = '0;
      if (data_read) begin
         rsp_rdata = reg_rdata;
         if (is_status) begin
            rsp_rdata[SDAD_BIT] = sticky_denied;
         end
      end
   end

   assign set_flag = rsp_err && dbg_pwr_on && idx_ok && (win == 3'(C_AUTH));
   assign clr_flag = data_read && is_status;

   dpa_sticky u_sticky (
      .clk  (clk),
      .rst_n(dbg_rst_n),
      .set_i(set_flag),
      .clr_i(clr_flag),
      .q_o  (sticky_denied)
   );

   a_r1_dbg_off_err: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !dbg_pwr_on |-> rsp_err && !rsp_wr_en);

   a_r1_dbg_off_keep: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !dbg_pwr_on |=> $stable(sticky_denied));

   a_r3_ext_port_no_slk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !acc_mmio |-> win != 3'(C_SLK));

   a_r5_write_blocked: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      rsp_code != PC_RW |-> !rsp_wr_en);

   a_r6_wi_reads_zero: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !acc_write && rsp_code == PC_WI |-> rsp_rdata == '0);

   a_r7_range_err: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !idx_ok |-> rsp_err);

   a_r8_auth_sets: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      rsp_err && dbg_pwr_on && idx_ok && win == 3'(C_AUTH) |=> sticky_denied);

   a_r9_other_keep: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      !acc_valid |=> $stable(sticky_denied));

   a_r10_status_clears: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      acc_valid && !acc_write && is_status && !rsp_err && rsp_code != PC_WI
      |=> !sticky_denied);

endmodule

// File: tb/dbg_perm_arbiter_bench.sv
module dbg_perm_arbiter_bench;

   localparam int DW = 32;
   localparam int SBIT = 6;

   logic clk = 1'b0;
   logic dbg_rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0, acc_mmio = 0;
   logic [2:0] acc_idx = '0;
   logic dbg_pwr_on = 1, pwr_up = 1, dbl_lock = 0, os_lock = 0;
   logic ext_dbg_allow = 1, sw_lock = 0;
   logic [DW-1:0] reg_rdata = '0;
   logic [2:0] rsp_code;
   logic rsp_err, rsp_wr_en, sticky_denied;
   logic [DW-1:0] rsp_rdata;

   int total = 0;
   int bad = 0;
   logic m_sticky = 1'b0;

   always #2 clk = ~clk;

   dbg_perm_arbiter u_dbg_perm_arbiter (
      .clk(clk), .dbg_rst_n(dbg_rst_n), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_mmio(acc_mmio), .acc_idx(acc_idx),
      .dbg_pwr_on(dbg_pwr_on), .pwr_up(pwr_up), .dbl_lock(dbl_lock),
      .os_lock(os_lock), .ext_dbg_allow(ext_dbg_allow), .sw_lock(sw_lock),
      .reg_rdata(reg_rdata), .rsp_code(rsp_code), .rsp_err(rsp_err),
      .rsp_wr_en(rsp_wr_en), .rsp_rdata(rsp_rdata), .sticky_denied(sticky_denied)
   );

   // bench copy of the permission rows, [register][condition]
   function automatic logic [2:0] tbl(input int r, input int c);
      logic [2:0] t [4][6];
      t[0] = '{3'd7, 3'd7, 3'd7, 3'd7, 3'd3, 3'd1};
      t[1] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd2};
      t[2] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd1};
      t[3] = '{3'd0, 3'd0, 3'd4, 3'd0, 3'd3, 3'd1};
      return t[r][c];
   endfunction

   // returns {auth_won, code}
   function automatic logic [3:0] model();
      logic [5:0] h;
      if (!dbg_pwr_on || acc_idx > 3'd3) return 4'b0000;
      h = {1'b1, sw_lock & acc_mmio, ~ext_dbg_allow, os_lock, dbl_lock, ~pwr_up};
      for (int c = 0; c < 6; c++) begin
         if (h[c] && tbl(int'(acc_idx), c) != 3'd7) begin
            logic [2:0] k;
            k = tbl(int'(acc_idx), c);
            if (k > 3'd4) k = 3'd0;
            return {(c == 3) && (k == 3'd0), k};
         end
      end
      return 4'b0000;
   endfunction

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // drive one access at the falling edge, check combinational response,
   // then advance the flag model across the rising edge
   task automatic step(input string tag);
      logic [3:0] m;
      logic [2:0] k;
      logic rd_ok;
      logic [DW-1:0] e_rd;
      logic e_err, e_wr;
      #1;
      m = model();
      k = m[2:0];
      rd_ok = acc_valid && !acc_write && (k == 3'd1 || k == 3'd2 || k == 3'd3);
      e_rd = rd_ok ? reg_rdata : '0;
      if (rd_ok && acc_idx == 3'd0) e_rd[SBIT] = m_sticky;
      e_err = acc_valid && (k == 3'd0);
      e_wr = acc_valid && acc_write && (k == 3'd1);
      check(sticky_denied == m_sticky, "R8", "sticky", 32'(sticky_denied), 32'(m_sticky));
      if (acc_valid) check(rsp_code == k, tag, "code", 32'(rsp_code), 32'(k));
      check(rsp_err == e_err, tag, "err", 32'(rsp_err), 32'(e_err));
      check(rsp_wr_en == e_wr, "R5", "wr_en", 32'(rsp_wr_en), 32'(e_wr));
      check(rsp_rdata == e_rd, "R6", "rdata", rsp_rdata, e_rd);
      @(posedge clk);
      if (acc_valid && m[3]) m_sticky = 1'b1;
      else if (rd_ok && acc_idx == 3'd0) m_sticky = 1'b0;
      @(negedge clk);
   endtask

   task automatic acc(input logic wr, input logic mm, input logic [2:0] idx);
      acc_valid = 1'b1; acc_write = wr; acc_mmio = mm; acc_idx = idx;
      reg_rdata = $urandom;
   endtask

   task automatic conds(input logic dp, input logic pu, input logic dl,
                        input logic ol, input logic al, input logic sl);
      dbg_pwr_on = dp; pwr_up = pu; dbl_lock = dl;
      os_lock = ol; ext_dbg_allow = al; sw_lock = sl;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      check(sticky_denied == 1'b0, "R11", "reset sticky", 32'(sticky_denied), 0);
      dbg_rst_n = 1'b1;
      @(negedge clk);

      // R2: normal access and each condition winning in turn
      conds(1, 1, 0, 0, 1, 0); acc(1, 1, 3'd2); step("R2");
      conds(1, 0, 1, 1, 0, 1); acc(0, 1, 3'd1); step("R2");
      conds(1, 1, 1, 1, 0, 1); acc(0, 1, 3'd2); step("R2");
      conds(1, 1, 0, 1, 0, 1); acc(0, 0, 3'd3); step("R6");
      conds(1, 1, 0, 0, 1, 0); acc(1, 0, 3'd1); step("R5");
      // R3: software lock ignored on the external port, honoured on mmio
      conds(1, 1, 0, 0, 1, 1); acc(1, 0, 3'd2); step("R3");
      conds(1, 1, 0, 0, 1, 1); acc(1, 1, 3'd2); step("R3");
      // R7: index out of range
      conds(1, 1, 0, 0, 1, 0); acc(0, 1, 3'd5); step("R7");
      // R1: debug power off with auth denied: error, no flag
      conds(0, 1, 0, 0, 0, 0); acc(0, 0, 3'd2); step("R1");
      check(sticky_denied == 1'b0, "R1", "flag after dbg off", 32'(sticky_denied), 0);
      // R9: error from OS lock does not set the flag
      conds(1, 1, 0, 1, 0, 0); acc(0, 0, 3'd2); step("R9");
      // R8: auth error sets the flag
      conds(1, 1, 0, 0, 0, 0); acc(0, 0, 3'd2); step("R8");
      acc_valid = 1'b0; step("R9");
      check(sticky_denied == 1'b1, "R8", "flag set", 32'(sticky_denied), 1);
      // R10: status read returns 1 and clears; next read returns 0
      conds(1, 1, 0, 0, 1, 0); acc(0, 0, 3'd0); step("R10");
      acc(0, 0, 3'd0); step("R10");
      check(sticky_denied == 1'b0, "R10", "flag cleared", 32'(sticky_denied), 0);
      // set and clear on back-to-back cycles
      for (int i = 0; i < 4; i++) begin
         conds(1, 1, 0, 0, 0, 0); acc(0, 1, 3'd1); step("R8");
         conds(1, 1, 0, 0, 0, 0); acc(0, 1, 3'd0); step("R10");
      end
      // R11: reset mid-run clears a set flag
      conds(1, 1, 0, 0, 0, 0); acc(1, 0, 3'd3); step("R8");
      acc_valid = 1'b0;
      dbg_rst_n = 1'b0; m_sticky = 1'b0;
      #1;
      check(sticky_denied == 1'b0, "R11", "reset clears", 32'(sticky_denied), 0);
      @(negedge clk); dbg_rst_n = 1'b1; @(negedge clk);

      // R4: random mix of conditions, ports and indices
      for (int i = 0; i < 400; i++) begin
         conds(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) == 0,
               ($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 2) == 0);
         acc(1'($urandom), 1'($urandom), 3'($urandom % 6));
         acc_valid = ($urandom % 8) != 0;
         step("R4");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule